// File: doc/BRIEF.md
# Intersection Light Sequencer

This block sequences the lights at a crossing where a busy east-west road meets a lightly used north-south road. Two request inputs arrive already synchronized to the clock. One is a walk request, the other is a north-south car detector. Each stays high until its request has been served. The block drives a 3-bit phase code, and external decoders turn that code into lamp and walk signals.

Internally, a Moore phase sequencer chooses the next phase, and a dwell counter decides when the current phase has run long enough. The counter raises an advance strobe, which it decodes from its count, the present phase and, on the main road, whether any request is pending. The east-west road stays green for as long as nobody asks for the crossing. A walker is always served before a waiting car. After a walk phase that interrupted north-south traffic, the east-west road always gets the next green.

Top module: `intersection_light_seq`

## Requirements
- R1: `light_state` reports the phase with these codes: 000 all-stop, 001 east-west green, 010 north-south green, 011 walk entered from east-west, 100 walk entered from north-south.
- R2: A synchronous active-high `rst` forces all-stop (000). All-stop then lasts exactly one cycle. It leaves by the east-west rule of R4: walk when `ped_req` is high, north-south when only `car_req` is high, otherwise east-west.
- R3: The phase holds on every clock edge where the advance strobe is low.
- R4: When east-west advances, it goes to walk (011) if `ped_req` is high, even if `car_req` is also high. It goes to north-south (010) if only `car_req` is high. While both requests are low, it stays at 001 indefinitely.
- R5: When north-south advances, it goes to walk (100) if `ped_req` is high. Otherwise it returns to east-west (001), even while `car_req` is still high.
- R6: When the walk phase entered from east-west advances, it goes to north-south if `car_req` is high and to east-west if it is not.
- R7: When the walk phase entered from north-south advances, it always goes to east-west, whatever the requests are.
- R8: Each walk phase lasts exactly 3 cycles and north-south lasts exactly 4 cycles. This holds even if a request drops during the phase.
- R9: In east-west with the counter parked at zero, the first edge that samples a request starts counting. The phase changes on the 7th edge counted from and including that one.
- R10: The dwell count returns to zero on the edge where the phase changes, so every phase times its dwell from a fresh start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ped_req | input | 1 | Walk request, synchronized, held until served |
| car_req | input | 1 | North-south car present, synchronized, held until served |
| light_state | output | 3 | Encoded phase for the lamp decoders |

## Verification
Two functions can coincide on the edge that ends east-west: the priority choice between a walker and a car, and the counter restart that times the next phase. The stimulus raises both requests together while east-west is parked. It then checks that the walk code appears on exactly the 7th edge, and that the walk phase lasts its full three cycles. The same coincidence is repeated when north-south ends with both requests still high. Here the walk phase must win, and it must be followed by an unconditional return to east-west.

// File: rtl/light_seq_pkg.sv
package light_seq_pkg;

    // Phase codes; external decoders depend on these values.
    typedef enum logic [2:0] {
        PH_STOP      = 3'b000,
        PH_MAIN      = 3'b001,
        PH_SIDE      = 3'b010,
        PH_WALK_MAIN = 3'b011,
        PH_WALK_SIDE = 3'b100
    } phase_e;

    typedef struct packed {
        phase_e phase;
    } seq_state_t;

endpackage

// File: rtl/phase_sequencer.sv
module phase_sequencer
    import light_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   advance,
    input  logic   ped_req,
    input  logic   car_req,
    output phase_e phase
);

    seq_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        case (state_q.phase)
            PH_STOP, PH_MAIN: begin
                if (advance) begin
                    if (ped_req)      state_d.phase = PH_WALK_MAIN;
                    else if (car_req) state_d.phase = PH_SIDE;
                    else              state_d.phase = PH_MAIN;
                end
            end
            PH_SIDE: begin
                if (advance) begin
                    state_d.phase = ped_req ? PH_WALK_SIDE : PH_MAIN;
                end
            end
            PH_WALK_MAIN: begin
                if (advance) begin
                    state_d.phase = car_req ? PH_SIDE : PH_MAIN;
                end
            end
            PH_WALK_SIDE: begin
                if (advance) begin
                    state_d.phase = PH_MAIN;
                end
            end
            default: state_d.phase = PH_STOP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '{phase: PH_STOP};
        else     state_q <= state_d;
    end

    assign phase = state_q.phase;

endmodule

// File: rtl/dwell_counter.sv
module dwell_counter
    import light_seq_pkg::*;
#(
    parameter int CNT_W       = 3,
    parameter int WALK_CYCLES = 3,
    parameter int SIDE_CYCLES = 4,
    parameter int MAIN_CYCLES = 7
) (
    input  logic             clk,
    input  logic             rst,
    input  phase_e           phase,
    input  logic             ped_req,
    input  logic             car_req,
    output logic             advance,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] WALK_LAST = CNT_W'(WALK_CYCLES - 1);
    localparam logic [CNT_W-1:0] SIDE_LAST = CNT_W'(SIDE_CYCLES - 1);
    localparam logic [CNT_W-1:0] MAIN_LAST = CNT_W'(MAIN_CYCLES - 1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_state_t;

    cnt_state_t cnt_d, cnt_q;
    logic             demand;
    logic             legal;
    logic             run;
    logic [CNT_W-1:0] last;

    assign demand = ped_req | car_req;

    // Per-phase end count and whether counting proceeds this cycle.
    always_comb begin
        legal = 1'b1;
        run   = 1'b1;
        last  = '0;
        case (phase)
            PH_STOP:      last = '0;
            PH_MAIN: begin
                last = MAIN_LAST;
                run  = (cnt_q.count != '0) | demand;
            end
            PH_SIDE:      last = SIDE_LAST;
            PH_WALK_MAIN,
            PH_WALK_SIDE: last = WALK_LAST;
            default:      legal = 1'b0;
        endcase
    end

    // Mealy strobe: count value, phase and (on the main road) demand.
    always_comb begin
        advance = legal && (cnt_q.count == last) &&
                  ((phase != PH_MAIN) || demand);
    end

    always_comb begin
        cnt_d = cnt_q;
        if (!legal || (cnt_q.count >= last) || advance) begin
            cnt_d.count = '0;
        end else if (run) begin
            cnt_d.count = cnt_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '{count: '0};
        else     cnt_q <= cnt_d;
    end

    assign count = cnt_q.count;

endmodule

// File: rtl/intersection_light_seq.sv
module intersection_light_seq
    import light_seq_pkg::*;
#(
    parameter int WALK_CYCLES = 3,
    parameter int SIDE_CYCLES = 4,
    parameter int MAIN_CYCLES = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ped_req,
    input  logic       car_req,
    output logic [2:0] light_state
);

    localparam int MAX_A      = (WALK_CYCLES > SIDE_CYCLES) ? WALK_CYCLES : SIDE_CYCLES;
    localparam int MAX_CYCLES = (MAX_A > MAIN_CYCLES) ? MAX_A : MAIN_CYCLES;
    localparam int CNT_W      = (MAX_CYCLES > 2) ? $clog2(MAX_CYCLES) : 1;

    phase_e           phase;
    logic             advance;
    logic [CNT_W-1:0] dwell_cnt;

    phase_sequencer u_seq (
        .clk     (clk),
        .rst     (rst),
        .advance (advance),
        .ped_req (ped_req),
        .car_req (car_req),
        .phase   (phase)
    );

    dwell_counter #(
        .CNT_W       (CNT_W),
        .WALK_CYCLES (WALK_CYCLES),
        .SIDE_CYCLES (SIDE_CYCLES),
        .MAIN_CYCLES (MAIN_CYCLES)
    ) u_dwell (
        .clk     (clk),
        .rst     (rst),
        .phase   (phase),
        .ped_req (ped_req),
        .car_req (car_req),
        .advance (advance),
        .count   (dwell_cnt)
    );

    assign light_state = phase;

endmodule

// File: rtl/light_seq_checker.sv
module light_seq_checker
    import light_seq_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input logic             clk,
    input logic             rst,
    input logic             ped_req,
    input logic [2:0]       light_state,
    input logic             advance,
    input logic [CNT_W-1:0] dwell_cnt
);

    p_stop_once_r2: assert property (@(posedge clk) disable iff (rst)
        (light_state == PH_STOP) |=> (light_state != PH_STOP));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !advance |=> (light_state == $past(light_state)));

    p_walk_priority_r4: assert property (@(posedge clk) disable iff (rst)
        (light_state == PH_MAIN && advance && ped_req) |=> (light_state == PH_WALK_MAIN));

    p_side_return_r5: assert property (@(posedge clk) disable iff (rst)
        (light_state == PH_SIDE && advance && !ped_req) |=> (light_state == PH_MAIN));

    p_walk_side_exit_r7: assert property (@(posedge clk) disable iff (rst)
        (light_state == PH_WALK_SIDE && advance) |=> (light_state == PH_MAIN));

    p_count_restart_r10: assert property (@(posedge clk) disable iff (rst)
        advance |=> (dwell_cnt == '0));

endmodule

bind intersection_light_seq light_seq_checker #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ped_req     (ped_req),
    .light_state (light_state),
    .advance     (advance),
    .dwell_cnt   (dwell_cnt)
);

// File: tb/test_intersection_light_seq.sv
`timescale 1ns/1ps
module test_intersection_light_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ped = 1'b0;
    logic       car = 1'b0;
    logic [2:0] light_state;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    intersection_light_seq i_intersection_light_seq (
        .clk         (clk),
        .rst         (rst),
        .ped_req     (ped),
        .car_req     (car),
        .light_state (light_state)
    );

    // Entry: [11:8] requirement number, [5] ped, [4] car, [2:0] expected code
    localparam int NVEC = 47;
    localparam logic [11:0] VEC [NVEC] = '{
        12'h101,                                     // R1 all-stop leaves to 001
        12'h301, 12'h301,                            // R3 idle hold
        12'h921, 12'h921, 12'h921, 12'h921, 12'h921, 12'h921, // R9 walk request counting
        12'h423,                                     // R4 walk taken
        12'h813, 12'h813,                            // R8 walk dwell
        12'h612,                                     // R6 car waiting -> 010
        12'h802, 12'h802, 12'h802,                   // R8 side dwell, car dropped
        12'h501,                                     // R5 back to 001
        12'h931, 12'h931, 12'h931, 12'h931, 12'h931, 12'h931, // R9 both requests
        12'h433,                                     // R4 walk beats car
        12'h833, 12'h833,                            // R8
        12'h612,                                     // R6 walk done, car -> 010
        12'h812, 12'h832, 12'h832,                   // R8 side dwell, walk arrives
        12'h534,                                     // R5 walk from side
        12'h834, 12'h814,                            // R8
        12'h711,                                     // R7 forced return with car waiting
        12'h911, 12'h911, 12'h911, 12'h911, 12'h911, 12'h911, // R9 car only
        12'h412,                                     // R4 car only -> 010
        12'h812, 12'h812, 12'h812,                   // R8
        12'h511,                                     // R5 return although car high
        12'h301, 12'h301                             // R3 parked
    };

    task automatic check(input logic [2:0] exp, input int req);
        n_checks++;
        if (light_state !== exp) begin
            n_fails++;
            $display("FAIL R%0d at %0t: light_state actual=%b expected=%b",
                     req, $time, light_state, exp);
        end
    endtask

    task automatic step(input logic p, input logic c, input logic [2:0] exp, input int req);
        ped = p;
        car = c;
        @(posedge clk);
        #1;
        check(exp, req);
    endtask

    task automatic pulse_reset();
        rst = 1'b1;
        @(posedge clk);
        #1;
        check(3'b000, 2);   // R2 reset forces all-stop
        rst = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(3'b000, 2);   // R2 reset state
        rst = 1'b0;

        for (int i = 0; i < NVEC; i++) begin
            step(VEC[i][5], VEC[i][4], VEC[i][2:0], int'(VEC[i][11:8]));
        end

        // R4: long idle stays on east-west
        for (int i = 0; i < 50; i++) step(1'b0, 1'b0, 3'b001, 4);
        // R9: car arrives, 7th edge changes phase
        for (int i = 0; i < 6; i++) step(1'b0, 1'b1, 3'b001, 9);
        step(1'b0, 1'b1, 3'b010, 4);
        // R8: side dwell with car gone
        for (int i = 0; i < 3; i++) step(1'b0, 1'b0, 3'b010, 8);
        step(1'b0, 1'b0, 3'b001, 5);

        // R2: reset in the middle of an east-west count
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 3'b001, 9);
        pulse_reset();
        step(1'b1, 1'b0, 3'b011, 2);               // R2 one stop cycle, walk chosen
        for (int i = 0; i < 2; i++) step(1'b0, 1'b0, 3'b011, 10); // R10 fresh dwell
        step(1'b0, 1'b0, 3'b001, 6);

        // R2: stop state with only a car goes straight to side green
        pulse_reset();
        step(1'b0, 1'b1, 3'b010, 2);
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 3'b010, 10);
        step(1'b0, 1'b1, 3'b001, 5);

        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL R3 watchdog: actual=still running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule